// File: doc/BRIEF.md
# Bit-Serial Real-Time-Clock Register Slave

This block is the device-side serial engine of a real-time-clock macro. A host drives three slow lines by software (frame enable, serial clock and data in) and watches two (data out and ready). Every line is oversampled in the system clock domain through a synchronizer. Rising edges of the serial clock are found with an edge detector.

The frame length is not fixed. In a write, the host sends the 32-bit value first and the register address after it. In a read, the host sends the address first and then clocks out 32 bits. In both cases the final address bit is the direction flag, and the host clocks it with enable already low. That low-enable edge is what closes the address. Two registers sit behind the engine: a seconds count that a one-second tick advances, and a general-purpose output word that feeds pin logic outside this block.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset, `ready_o` is 1, `dout_o` is 0, `seconds_o` is 0 and `gpo_o` equals the `GPO_RESET` parameter (default 0).
- R2: `ready_o` falls within four system clocks after `en_i` is raised while idle. It stays low until the frame completes, is rejected or times out, and is 1 again within six clocks after that.
- R3: A write frame has three parts, each sent most significant bit first. First come 32 data bits and then the 3-bit register index, all clocked on serial-clock rising edges with `en_i` high. Then one further edge with `en_i` low carries the direction bit, where 1 means write. Index 0 loads `seconds_o` with the data and index 1 loads `gpo_o`.
- R4: A read frame has two parts. First the 3-bit index is clocked with `en_i` high. Then a direction bit of 0 is clocked with `en_i` low. After the k-th following rising edge (k = 1..32), `dout_o` shows bit 32-k of the register, so bit 31 comes first. `dout_o` holds that value until the next edge.
- R5: Each system clock with `tick_i` high increments the seconds count by one, wrapping from 0xFFFFFFFF to 0. A write to index 0 in the same clock takes precedence over the tick.
- R6: A write to an index other than 0 or 1 changes no register. A read of such an index returns 32 zero bits.
- R7: The closing edge is rejected, returning the engine to idle with no register change, in two cases. A direction bit of 1 is rejected unless exactly 35 enable-high edges preceded it. A direction bit of 0 is rejected unless exactly 3 preceded it.
- R8: If a frame is active and no serial-clock rising edge arrives for `TIMEOUT_CYC` system clocks, the engine returns to idle, raises `ready_o` and writes nothing.
- R9: While idle with `en_i` low, serial-clock edges and data-in changes have no effect: `ready_o` stays 1 and no register changes.
- R10: A read returns the register value captured on the direction-bit edge. Ticks arriving during the 32 data-out edges do not alter the bits returned, but they still advance `seconds_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Frame enable from host (asynchronous) |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| din_i | input | 1 | Serial data from host (asynchronous) |
| tick_i | input | 1 | One-second pulse, synchronous to clk |
| dout_o | output | 1 | Serial data to host |
| ready_o | output | 1 | High when a new frame may start |
| seconds_o | output | DATA_W | Current seconds count |
| gpo_o | output | DATA_W | General-purpose output control word |

## Verification
The hardest case to reach from the ports is the closing edge arriving with the wrong number of enable-high bits before it. Good frames always have 35 or 3 such edges. The bench therefore drives frames with other counts, 20 bits with direction 1 and 4 bits with direction 0, and then confirms through both register ports and a later read that nothing moved. A second hard case is a stall in the middle of a frame. The bench reaches it by abandoning a frame after five bits and waiting past the timeout with enable low. Ticks are also injected inside a read's data phase to separate the captured value from the live count.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_SEND    = 2'd2
   } frame_st_t;

   localparam int IDX_SECONDS = 0;
   localparam int IDX_GPO     = 1;
endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   initial assert (STAGES >= 1 && WIDTH >= 1) else $fatal(1, "rtc_ser_sync: bad parameters");

   generate
      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '0;
            else        q <= async_i;
         assign sync_o = q;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '0;
            else        q <= {q[STAGES-2:0], async_i};
         assign sync_o = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rtc_ser_regs.sv
module rtc_ser_regs import rtc_ser_pkg::*; #(
   parameter int                DATA_W    = 32,
   parameter int                IDX_W     = 3,
   parameter logic [DATA_W-1:0] GPO_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_stb,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] sec_o,
   output logic [DATA_W-1:0] gpo_o
);
   localparam logic [IDX_W-1:0] SEL_SEC = IDX_W'(IDX_SECONDS);
   localparam logic [IDX_W-1:0] SEL_GPO = IDX_W'(IDX_GPO);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                             sec_o <= '0;
      else if (wr_stb && wr_idx == SEL_SEC)   sec_o <= wr_data;
      else if (tick)                          sec_o <= sec_o + DATA_W'(1);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                             gpo_o <= GPO_RESET;
      else if (wr_stb && wr_idx == SEL_GPO)   gpo_o <= wr_data;

   always_comb begin
      if (rd_idx == SEL_SEC)      rd_data = sec_o;
      else if (rd_idx == SEL_GPO) rd_data = gpo_o;
      else                        rd_data = '0;
   end
endmodule

// File: rtl/rtc_ser_frame.sv
module rtc_ser_frame import rtc_ser_pkg::*; #(
   parameter int DATA_W      = 32,
   parameter int IDX_W       = 3,
   parameter int TIMEOUT_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              en_s,
   input  logic              din_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_stb,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              dout,
   output logic              ready,
   output logic              edge_o,
   output logic              send_o,
   output logic              tmo_o
);
   localparam int WR_BITS = DATA_W + IDX_W;
   localparam int CNT_W   = $clog2(WR_BITS + 2);
   localparam int TX_W    = $clog2(DATA_W + 1);
   localparam int TO_W    = $clog2(TIMEOUT_CYC + 1);

   initial assert (DATA_W >= 2 && IDX_W >= 1 && TIMEOUT_CYC >= 2)
      else $fatal(1, "rtc_ser_frame: bad parameters");

   frame_st_t          st;
   logic               sclk_q;
   logic [WR_BITS-1:0] sh;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  tx;
   logic [TX_W-1:0]    txcnt;
   logic [TO_W-1:0]    tcnt;
   logic               rise, dir_edge, rd_ok, tmo;

   assign rise     = sclk_s & ~sclk_q;
   assign dir_edge = rise & ~en_s & (st == ST_COLLECT);
   assign wr_stb   = dir_edge & din_s & (cnt == CNT_W'(WR_BITS));
   assign rd_ok    = dir_edge & ~din_s & (cnt == CNT_W'(IDX_W));
   assign tmo      = (st != ST_IDLE) & ~rise & (tcnt == TO_W'(TIMEOUT_CYC - 1));
   assign wr_idx   = sh[IDX_W-1:0];
   assign rd_idx   = sh[IDX_W-1:0];
   assign wr_data  = sh[WR_BITS-1:IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sclk_q <= 1'b0;
         sh     <= '0;
         cnt    <= '0;
         tx     <= '0;
         txcnt  <= '0;
         tcnt   <= '0;
         dout   <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         if (st == ST_IDLE || rise) tcnt <= '0;
         else                       tcnt <= tcnt + TO_W'(1);
         if (tmo) st <= ST_IDLE;
         else begin
            case (st)
               ST_IDLE: if (en_s) begin
                  st   <= ST_COLLECT;
                  cnt  <= '0;
                  dout <= 1'b0;
               end
               ST_COLLECT: if (rise) begin
                  if (en_s) begin
                     sh <= {sh[WR_BITS-2:0], din_s};
                     if (cnt != CNT_W'(WR_BITS + 1)) cnt <= cnt + CNT_W'(1);
                  end else if (rd_ok) begin
                     st    <= ST_SEND;
                     tx    <= rd_data;
                     txcnt <= '0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
               ST_SEND: if (rise) begin
                  dout  <= tx[DATA_W-1];
                  tx    <= {tx[DATA_W-2:0], 1'b0};
                  txcnt <= txcnt + TX_W'(1);
                  if (txcnt == TX_W'(DATA_W - 1)) st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign ready  = (st == ST_IDLE);
   assign send_o = (st == ST_SEND);
   assign edge_o = rise;
   assign tmo_o  = tmo;
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave #(
   parameter int                DATA_W      = 32,
   parameter int                IDX_W       = 3,
   parameter int                SYNC_STAGES = 2,
   parameter int                TIMEOUT_CYC = 1024,
   parameter logic [DATA_W-1:0] GPO_RESET   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              sclk_i,
   input  logic              din_i,
   input  logic              tick_i,
   output logic              dout_o,
   output logic              ready_o,
   output logic [DATA_W-1:0] seconds_o,
   output logic [DATA_W-1:0] gpo_o
);
   logic              sclk_s, en_s, din_s;
   logic              wr_stb, edge_s, send_s, tmo_s;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, rd_data;

   rtc_ser_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .async_i({sclk_i, en_i, din_i}),
      .sync_o({sclk_s, en_s, din_s})
   );

   rtc_ser_frame #(.DATA_W(DATA_W), .IDX_W(IDX_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .en_s(en_s), .din_s(din_s),
      .rd_data(rd_data), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .dout(dout_o), .ready(ready_o), .edge_o(edge_s),
      .send_o(send_s), .tmo_o(tmo_s)
   );

   rtc_ser_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .GPO_RESET(GPO_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .sec_o(seconds_o), .gpo_o(gpo_o)
   );
endmodule

// File: rtl/rtc_ser_chk.sv
module rtc_ser_chk #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_s,
   input logic              tick_i,
   input logic              wr_stb,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              edge_s,
   input logic              send_s,
   input logic              tmo_s,
   input logic              ready_o,
   input logic              dout_o,
   input logic [DATA_W-1:0] seconds_o,
   input logic [DATA_W-1:0] gpo_o
);
   logic wr_sec, wr_gpo;
   assign wr_sec = wr_stb && wr_idx == IDX_W'(0);
   assign wr_gpo = wr_stb && wr_idx == IDX_W'(1);

   assert_sec_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sec |=> seconds_o == $past(wr_data));
   assert_gpo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gpo |=> gpo_o == $past(wr_data));
   assert_tick_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !wr_sec) |=> seconds_o == $past(seconds_o) + DATA_W'(1));
   assert_gpo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_gpo |=> $stable(gpo_o));
   assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && en_s) |=> !ready_o);
   assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_s |=> ready_o);
   assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (send_s && !edge_s) |=> $stable(dout_o));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !en_s) |=> ready_o);
endmodule

bind rtc_serial_slave rtc_ser_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_s(en_s), .tick_i(tick_i), .wr_stb(wr_stb),
   .wr_idx(wr_idx), .wr_data(wr_data), .edge_s(edge_s), .send_s(send_s),
   .tmo_s(tmo_s), .ready_o(ready_o), .dout_o(dout_o),
   .seconds_o(seconds_o), .gpo_o(gpo_o)
);

// File: tb/sim_rtc_serial_slave.sv
module sim_rtc_serial_slave;
   localparam int H   = 4;
   localparam int TMO = 300;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 1'b0, sclk = 1'b0, din = 1'b0, tick = 1'b0;
   logic dout, ready;
   logic [31:0] sec, gpo;
   logic [31:0] m_sec = 0, m_gpo = 0;
   int nchk = 0, nfail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rtc_serial_slave #(.TIMEOUT_CYC(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en), .sclk_i(sclk), .din_i(din),
      .tick_i(tick), .dout_o(dout), .ready_o(ready), .seconds_o(sec), .gpo_o(gpo)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); din = b;
      waitc(H); sclk = 1'b1;
      waitc(H); sclk = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      m_sec = m_sec + 1;
   endtask

   task automatic raw_frame(input int n, input logic [63:0] bits, input logic dir);
      @(negedge clk); en = 1'b1;
      waitc(H);
      chk("R2 ready low after enable", {31'd0, ready}, 32'd0);
      for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
      @(negedge clk); en = 1'b0;
      send_bit(dir);
      din = 1'b0;
   endtask

   function automatic logic [31:0] model_read(input int idx);
      if (idx == 0) return m_sec;
      if (idx == 1) return m_gpo;
      return 32'd0;
   endfunction

   task automatic write_frame(input logic [2:0] idx, input logic [31:0] data);
      raw_frame(35, {29'd0, data, idx}, 1'b1);
      if (idx == 0) m_sec = data;
      else if (idx == 1) m_gpo = data;
      waitc(6);
      chk("R2 ready high after write", {31'd0, ready}, 32'd1);
   endtask

   task automatic read_frame(input logic [2:0] idx, input int mid_ticks, output logic [31:0] got);
      got = '0;
      raw_frame(3, {61'd0, idx}, 1'b0);
      for (int k = 0; k < 32; k++) begin
         send_bit(1'b0);
         got = {got[30:0], dout};
         if (k == 4) for (int t = 0; t < mid_ticks; t++) do_tick();
      end
      waitc(6);
      chk("R2 ready high after read", {31'd0, ready}, 32'd1);
   endtask

   initial begin
      logic [31:0] r, d;
      int op, ix;
      r = $urandom(32'd7741);
      waitc(5);
      chk("R1 ready", {31'd0, ready}, 32'd1);
      chk("R1 dout", {31'd0, dout}, 32'd0);
      chk("R1 seconds", sec, 32'd0);
      chk("R1 gpo", gpo, 32'd0);
      rst_n = 1'b1;
      waitc(3);

      write_frame(3'd0, 32'h1234_5678);
      chk("R3 seconds load", sec, m_sec);
      write_frame(3'd1, 32'h0050_0000);
      chk("R3 gpo load", gpo, m_gpo);
      read_frame(3'd0, 0, r);
      chk("R4 read seconds", r, 32'h1234_5678);
      read_frame(3'd1, 0, r);
      chk("R4 read gpo", r, 32'h0050_0000);

      for (int i = 0; i < 3; i++) do_tick();
      waitc(2);
      chk("R5 tick count", sec, m_sec);
      write_frame(3'd0, 32'hFFFF_FFFF);
      do_tick();
      waitc(2);
      chk("R5 wrap", sec, 32'd0);

      write_frame(3'd5, 32'hDEAD_BEEF);
      chk("R6 unknown write seconds", sec, m_sec);
      chk("R6 unknown write gpo", gpo, m_gpo);
      read_frame(3'd3, 0, r);
      chk("R6 unknown read", r, 32'd0);

      raw_frame(20, 64'hA_5A5A, 1'b1);
      waitc(6);
      chk("R7 short write ready", {31'd0, ready}, 32'd1);
      chk("R7 short write seconds", sec, m_sec);
      chk("R7 short write gpo", gpo, m_gpo);
      raw_frame(4, 64'h2, 1'b0);
      waitc(6);
      chk("R7 long read header ready", {31'd0, ready}, 32'd1);
      read_frame(3'd1, 0, r);
      chk("R7 recovery read", r, m_gpo);

      @(negedge clk); en = 1'b1;
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      @(negedge clk); en = 1'b0; din = 1'b0;
      waitc(40);
      chk("R8 still busy before timeout", {31'd0, ready}, 32'd0);
      waitc(TMO + 20);
      chk("R8 ready after timeout", {31'd0, ready}, 32'd1);
      chk("R8 seconds untouched", sec, m_sec);
      chk("R8 gpo untouched", gpo, m_gpo);

      for (int i = 0; i < 10; i++) send_bit(i[0]);
      waitc(4);
      chk("R9 idle ready", {31'd0, ready}, 32'd1);
      chk("R9 idle seconds", sec, m_sec);
      chk("R9 idle gpo", gpo, m_gpo);

      write_frame(3'd0, 32'h0000_1000);
      d = m_sec;
      read_frame(3'd0, 3, r);
      chk("R10 snapshot value", r, d);
      chk("R10 live count", sec, m_sec);

      for (int it = 0; it < 24; it++) begin
         op = int'($urandom % 4);
         case (op)
            0: begin
               ix = int'($urandom % 2);
               write_frame(3'(ix), $urandom);
               chk(ix == 0 ? "R3 rand seconds" : "R3 rand gpo", ix == 0 ? sec : gpo, model_read(ix));
            end
            1: begin
               ix = int'($urandom % 2);
               read_frame(3'(ix), 0, r);
               chk("R4 rand read", r, model_read(ix));
            end
            2: begin
               for (int t = 0; t < int'($urandom % 5); t++) do_tick();
               waitc(2);
               chk("R5 rand ticks", sec, m_sec);
            end
            default: begin
               ix = 2 + int'($urandom % 6);
               read_frame(3'(ix), 0, r);
               chk("R6 rand unknown read", r, 32'd0);
            end
         endcase
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule